// File: doc/BRIEF.md
# Burst Address Generator

This block produces the word address presented to the array of a synchronous burst SRAM. A cycle can begin an access in two ways. A processor-side start strobe is accepted only while the chip is selected. A controller-side start strobe is always accepted. Either strobe captures the external address. Once an access has begun, each cycle with the advance input high moves the two least significant address bits one beat along a four-word burst. The upper address bits keep the value captured at the start.

A static order input selects the beat sequence. In linear order the low bits count upward and wrap modulo four. In interleaved order the low bits are the captured low bits XOR a beat counter. Bursting is optional: the datapath can load a fresh external address on every cycle with no lost cycles. Alongside the address, the block gives the datapath a valid flag and a flag that marks an address produced by an advance step.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset, `arrAddr` is 0 and both `accessValid` and `accessAdvanced` are 0.
- R2: With `ctrlStart`=1 at a rising edge, from that edge `arrAddr` equals the `extAddr` sampled there, `accessValid`=1 and `accessAdvanced`=0, whatever the value of `chipSel`.
- R3: With `procStart`=1 and `chipSel`=1 at a rising edge, the address loads in the same way as R2. With `procStart`=1, `chipSel`=0 and no other strobe, the outputs do not change.
- R4: When `ctrlStart` and `procStart` are both high, the controller strobe wins and the address loads even while `chipSel`=0. A start strobe also takes priority over `advance` in the same cycle.
- R5: With `linearOrder`=1, after n advance steps since the load, `arrAddr[1:0]` equals (loaded low bits + n) mod 4. Example: 1,2,3,0.
- R6: With `linearOrder`=0, after n advance steps since the load, `arrAddr[1:0]` equals loaded low bits XOR (n mod 4). Example: 1,0,3,2. A mode input tied low therefore gives interleaved order.
- R7: Advance steps never change `arrAddr[ADDR_W-1:2]`. After four steps the low bits are back at the loaded value.
- R8: In a cycle with no accepted start strobe and `advance`=0, `arrAddr` holds its value and `accessAdvanced` goes to 0.
- R9: `advance` has no effect while `accessValid`=0, that is, before the first load after reset.
- R10: Start strobes on consecutive cycles load each new `extAddr` on the edge where it is presented, with no idle cycles.
- R11: `accessAdvanced` is 1 in exactly those cycles that follow an edge at which an advance step was taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| extAddr | input | ADDR_W | External word address |
| procStart | input | 1 | Processor-side start strobe; accepted only while selected |
| ctrlStart | input | 1 | Controller-side start strobe; always accepted, highest priority |
| chipSel | input | 1 | Chip selected (1) |
| advance | input | 1 | Step to the next beat of the burst |
| linearOrder | input | 1 | 1 = linear wrap order, 0 = interleaved order |
| arrAddr | output | ADDR_W | Current array word address |
| accessValid | output | 1 | An address has been loaded since reset |
| accessAdvanced | output | 1 | Current address came from an advance step |

## Verification
Bursts are started from low bits 1 and 3 in both orders. Linear and interleaved sequences coincide for some start values and differ for others, so these starts tell the sequences apart. Each burst is run through a full wrap so that carries out of the low bits would show up. Advances are mixed with idle cycles, which distinguishes stepping on `advance` from stepping every cycle. The processor strobe is applied while deselected and while selected, alone and together with the controller strobe, to test the acceptance and priority rules. Back-to-back loads and advance-before-load separate the non-burst use from the burst use.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
  // Strobes from the control section to the address datapath
  typedef struct packed {
    logic load;  // capture external address, restart beat count
    logic step;  // move to next beat
  } burstStrobe_t;
endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_addr_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         procStart,
  input  logic         ctrlStart,
  input  logic         chipSel,
  input  logic         advance,
  output burstStrobe_t strobe,
  output logic         accessValid,
  output logic         accessAdvanced
);
  logic validQ;
  logic advQ;
  logic loadReq;

  // Controller strobe is unconditional; processor strobe needs selection.
  always_comb begin
    loadReq      = ctrlStart | (procStart & chipSel);
    strobe.load  = loadReq;
    strobe.step  = ~loadReq & advance & validQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= 1'b0;
      advQ   <= 1'b0;
    end else begin
      validQ <= validQ | loadReq;
      advQ   <= strobe.step;
    end
  end

  assign accessValid    = validQ;
  assign accessAdvanced = advQ;
endmodule

// File: rtl/burst_path.sv
module burst_path
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  burstStrobe_t      strobe,
  input  logic [ADDR_W-1:0] extAddr,
  input  logic              linearOrder,
  output logic [ADDR_W-1:0] arrAddr
);
  localparam int UPPER_W = ADDR_W - BEAT_W;

  logic [UPPER_W-1:0] upperQ;
  logic [BEAT_W-1:0]  baseQ;
  logic [BEAT_W-1:0]  beatQ;
  logic [BEAT_W-1:0]  lowSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      upperQ <= '0;
      baseQ  <= '0;
      beatQ  <= '0;
    end else if (strobe.load) begin
      upperQ <= extAddr[ADDR_W-1:BEAT_W];
      baseQ  <= extAddr[BEAT_W-1:0];
      beatQ  <= '0;
    end else if (strobe.step) begin
      beatQ  <= beatQ + 1'b1;
    end
  end

  // Order applied after the counter: one adder or one XOR level
  always_comb begin
    if (linearOrder) lowSel = baseQ + beatQ;
    else             lowSel = baseQ ^ beatQ;
  end

  assign arrAddr = {upperQ, lowSel};
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] extAddr,
  input  logic              procStart,
  input  logic              ctrlStart,
  input  logic              chipSel,
  input  logic              advance,
  input  logic              linearOrder,
  output logic [ADDR_W-1:0] arrAddr,
  output logic              accessValid,
  output logic              accessAdvanced
);
  burstStrobe_t strobe;

  burst_ctrl u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .procStart      (procStart),
    .ctrlStart      (ctrlStart),
    .chipSel        (chipSel),
    .advance        (advance),
    .strobe         (strobe),
    .accessValid    (accessValid),
    .accessAdvanced (accessAdvanced)
  );

  burst_path #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_path (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .extAddr     (extAddr),
    .linearOrder (linearOrder),
    .arrAddr     (arrAddr)
  );
endmodule

// File: rtl/burst_addr_chk.sv
module burst_addr_chk #(
  parameter int ADDR_W = 15,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] extAddr,
  input logic              procStart,
  input logic              ctrlStart,
  input logic              chipSel,
  input logic              advance,
  input logic              linearOrder,
  input logic [ADDR_W-1:0] arrAddr,
  input logic              accessValid,
  input logic              accessAdvanced
);
  logic accepted;
  logic stepping;
  assign accepted = ctrlStart | (procStart & chipSel);
  assign stepping = !accepted && advance && accessValid;

  // R2 and R4: controller strobe always loads
  a_r2_ctrl_load: assert property (@(posedge clk) disable iff (!rstN)
    ctrlStart |=> (arrAddr == $past(extAddr)) && accessValid && !accessAdvanced);

  // R3: selected processor strobe loads
  a_r3_proc_load: assert property (@(posedge clk) disable iff (!rstN)
    (procStart && chipSel) |=> (arrAddr == $past(extAddr)) && accessValid);

  // R3 and R8: nothing accepted and no advance means hold
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!accepted && !advance) |=>
      ($stable(arrAddr) || !$stable(linearOrder)) && !accessAdvanced);

  // R7 and R11: a step keeps the upper bits and flags the address
  a_r7_upper_kept: assert property (@(posedge clk) disable iff (!rstN)
    stepping |=> $stable(arrAddr[ADDR_W-1:BEAT_W]) && accessAdvanced);

  // R5: linear step adds one to the low bits
  a_r5_linear_step: assert property (@(posedge clk) disable iff (!rstN)
    (stepping && linearOrder) |=>
      (!linearOrder ||
       arrAddr[BEAT_W-1:0] == BEAT_W'($past(arrAddr[BEAT_W-1:0]) + 1'b1)));

  // R6: interleaved step always changes the low bits
  a_r6_interleave_moves: assert property (@(posedge clk) disable iff (!rstN)
    (stepping && !linearOrder) |=>
      (linearOrder || arrAddr[BEAT_W-1:0] != $past(arrAddr[BEAT_W-1:0])));

  // R9: advance before any load changes nothing
  a_r9_idle_advance: assert property (@(posedge clk) disable iff (!rstN)
    (!accessValid && !accepted) |=> !accessValid && !accessAdvanced);
endmodule

bind burst_addr_gen burst_addr_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
  .clk            (clk),
  .rstN           (rstN),
  .extAddr        (extAddr),
  .procStart      (procStart),
  .ctrlStart      (ctrlStart),
  .chipSel        (chipSel),
  .advance        (advance),
  .linearOrder    (linearOrder),
  .arrAddr        (arrAddr),
  .accessValid    (accessValid),
  .accessAdvanced (accessAdvanced)
);

// File: tb/burst_addr_gen_bench.sv
module burst_addr_gen_bench;
  localparam int ADDR_W = 15;
  localparam int BEAT_W = 2;
  localparam int UPPER_W = ADDR_W - BEAT_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] extAddr = '0;
  logic              procStart = 1'b0;
  logic              ctrlStart = 1'b0;
  logic              chipSel = 1'b0;
  logic              advance = 1'b0;
  logic              linearOrder = 1'b0;
  logic [ADDR_W-1:0] arrAddr;
  logic              accessValid;
  logic              accessAdvanced;

  always #4 clk = ~clk;  // 125 MHz

  burst_addr_gen #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_burst_addr_gen (
    .clk(clk), .rstN(rstN), .extAddr(extAddr), .procStart(procStart),
    .ctrlStart(ctrlStart), .chipSel(chipSel), .advance(advance),
    .linearOrder(linearOrder), .arrAddr(arrAddr), .accessValid(accessValid),
    .accessAdvanced(accessAdvanced)
  );

  int checks = 0;
  int fails = 0;
  bit driving = 1'b0;
  bit finished = 1'b0;

  // Scoreboard queues
  logic [ADDR_W-1:0] qAddr[$];
  logic              qValid[$];
  logic              qAdv[$];
  string             qTag[$];

  // Reference state
  logic [UPPER_W-1:0] mUpper = '0;
  logic [BEAT_W-1:0]  mBase = '0;
  logic [BEAT_W-1:0]  mBeat = '0;
  logic               mValid = 1'b0;
  logic               mAdv = 1'b0;

  task automatic drive(input bit c, input bit p, input bit s, input bit a,
                       input bit lin, input logic [ADDR_W-1:0] addr,
                       input string tag);
    logic [BEAT_W-1:0] low;
    @(negedge clk);
    ctrlStart = c; procStart = p; chipSel = s; advance = a;
    linearOrder = lin; extAddr = addr;
    if (c || (p && s)) begin
      mUpper = addr[ADDR_W-1:BEAT_W];
      mBase  = addr[BEAT_W-1:0];
      mBeat  = '0;
      mValid = 1'b1;
      mAdv   = 1'b0;
    end else if (a && mValid) begin
      mBeat = mBeat + 1'b1;
      mAdv  = 1'b1;
    end else begin
      mAdv = 1'b0;
    end
    low = lin ? BEAT_W'(mBase + mBeat) : (mBase ^ mBeat);
    qAddr.push_back({mUpper, low});
    qValid.push_back(mValid);
    qAdv.push_back(mAdv);
    qTag.push_back(tag);
  endtask

  // Monitor: sample 2 ns after each edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (driving && qAddr.size() > 0) begin
        logic [ADDR_W-1:0] eA;
        logic eV;
        logic eD;
        string t;
        eA = qAddr.pop_front(); eV = qValid.pop_front();
        eD = qAdv.pop_front();  t = qTag.pop_front();
        checks++;
        if (arrAddr !== eA || accessValid !== eV || accessAdvanced !== eD) begin
          fails++;
          $display("FAIL %s: addr=%h valid=%b adv=%b expected addr=%h valid=%b adv=%b",
                   t, arrAddr, accessValid, accessAdvanced, eA, eV, eD);
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    checks++;
    if (arrAddr !== '0 || accessValid !== 1'b0 || accessAdvanced !== 1'b0) begin
      fails++;
      $display("FAIL R1: addr=%h valid=%b adv=%b expected addr=0 valid=0 adv=0",
               arrAddr, accessValid, accessAdvanced);
    end
    @(negedge clk);
    rstN = 1'b1;
    driving = 1'b1;
    // R9: advance before any load is ignored
    drive(0, 0, 1, 1, 1, 15'h1235, "R9 advance before load");
    drive(0, 1, 0, 1, 1, 15'h1235, "R9 deselected start then advance");
    // R2: controller load while deselected, linear burst from low bits 1
    drive(1, 0, 0, 0, 1, 15'h2A51, "R2 ctrl load deselected");
    drive(0, 0, 0, 1, 1, 15'h7FFF, "R5 linear beat1");
    drive(0, 0, 0, 1, 1, 15'h7FFF, "R5 linear beat2");
    drive(0, 0, 0, 0, 1, 15'h7FFF, "R8 hold mid burst");
    drive(0, 0, 0, 1, 1, 15'h7FFF, "R5 linear beat3 wrap");
    drive(0, 0, 0, 1, 1, 15'h7FFF, "R7 linear back to start");
    drive(0, 0, 0, 0, 1, 15'h0000, "R8 hold after burst");
    // R3: processor strobe ignored when deselected, honored when selected
    drive(0, 1, 0, 0, 1, 15'h0444, "R3 proc ignored deselected");
    drive(0, 1, 1, 0, 0, 15'h3C03, "R3 proc load selected");
    // R6: interleaved from low bits 3: 3,2,1,0
    drive(0, 0, 1, 1, 0, 15'h0000, "R6 interleave beat1");
    drive(0, 0, 1, 1, 0, 15'h0000, "R6 interleave beat2");
    drive(0, 0, 1, 1, 0, 15'h0000, "R6 interleave beat3");
    drive(0, 0, 1, 1, 0, 15'h0000, "R7 interleave wrap");
    // R6: interleaved from low bits 1: 1,0,3,2
    drive(1, 0, 1, 0, 0, 15'h5551, "R2 ctrl load selected");
    drive(0, 0, 1, 1, 0, 15'h0000, "R6 interleave from 1 beat1");
    drive(0, 0, 1, 0, 0, 15'h0000, "R11 idle clears advanced flag");
    drive(0, 0, 1, 1, 0, 15'h0000, "R6 interleave from 1 beat2");
    drive(0, 0, 1, 1, 0, 15'h0000, "R6 interleave from 1 beat3");
    // R4: priority rules
    drive(1, 1, 0, 0, 1, 15'h1112, "R4 both strobes while deselected");
    drive(0, 0, 0, 1, 1, 15'h0000, "R5 linear from 2");
    drive(1, 0, 0, 1, 1, 15'h6663, "R4 start beats advance");
    drive(0, 1, 1, 1, 1, 15'h0F0E, "R4 proc start beats advance");
    // R10: back-to-back loads
    drive(1, 0, 0, 0, 0, 15'h0101, "R10 load a");
    drive(0, 1, 1, 0, 0, 15'h2202, "R10 load b");
    drive(1, 0, 1, 0, 1, 15'h7FFF, "R10 load c");
    drive(0, 0, 1, 1, 1, 15'h0000, "R7 linear from 3 keeps upper");
    @(negedge clk);
    advance = 1'b0;
    while (qAddr.size() > 0) @(negedge clk);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  // Watchdog
  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule